// File: doc/BRIEF.md
# Security violation interrupt aggregator

This block gathers level-sensitive violation indications from three kinds of neighbour: the peripheral protection controllers, the memory protection checkers, and the security wrappers that sit in front of bus masters. Each kind lands in its own status word, at fixed and sparse bit positions. For the protection controllers and the master wrappers, software gets an enable word and a write-one-to-clear word. Clear and enable actions are passed back to each source on dedicated wires. The wrapper status, gated by its enable word, is also reduced to one combined interrupt line.

The block also holds a small set of configuration bits that drive output pins directly. One is a 2-bit gating field and one is a 1-bit response-mode flag. A bridge-error group is kept register-compatible: its status always reads zero, its enable word stores only the upper half, and its clear word does nothing. Register access uses a simple 32-bit write strobe with byte strobes and a combinational read port, and is reachable only from the secure side of the fabric.

Register map (byte offsets, word aligned): 0x00 response flag, 0x04 gating field, 0x08 memory-checker status, 0x10 controller status, 0x14 controller clear, 0x18 controller enable, 0x20 wrapper status, 0x24 wrapper clear, 0x28 wrapper enable, 0x2C wrapper non-secure word, 0x30 bridge status, 0x34 bridge clear, 0x38 bridge enable.

Top module: `secviol_agg`

## Requirements
- R1: After reset every output is low, and the registers at 0x00, 0x04, 0x10, 0x18, 0x28, 0x2C and 0x38 read zero.
- R2: Controller source index i maps to a status bit position. Indices 0..1 go to bits 0..1, indices 2..5 to bits 4..7, and indices 6..9 to bits 20..23, so the implemented mask is 0x00F000F3. When a source line differs from its value on the previous cycle, its status bit in word 0x10 takes the new level one clock later.
- R3: A write to 0x14 clears each controller status bit whose written bit is 1. If a source changes level in the same cycle, its bit takes the new level instead. Word 0x14 reads as zero.
- R4: In the cycle after a write to 0x14, output `ctrl_clr_o[i]` pulses high for exactly one cycle with the value of source i's status bit after that write. Otherwise `ctrl_clr_o` is zero.
- R5: A write to 0x18 stores the written value limited to mask 0x00F000F3, and the stored value reads back. `ctrl_en_o[i]` equals the stored bit at source i's position (R2).
- R6: Word 0x08 holds memory-checker internal input n at bit n and expansion input n at bit n+16, sampled every clock. Writes to 0x08 have no effect.
- R7: Wrapper input n appears at bit n+16 of word 0x20, sampled every clock. Word 0x28 stores all 32 written bits. `wrap_irq_o` is high exactly when word 0x20 AND word 0x28 is nonzero.
- R8: A write to 0x24 drives `wrap_clr_o[n]` with written bit n+16 for exactly one cycle after the write, and 0x24 reads as zero.
- R9: Word 0x2C stores all 32 written bits and reads them back. `wrap_ns_o[n]` equals its bit n+16.
- R10: Word 0x30 always reads zero. Word 0x38 keeps only written bits 31:16. A write to 0x34 changes nothing, and 0x34 reads as zero.
- R11: Word 0x04 keeps written bits 1:0 and drives `gate_cfg_o`. Word 0x00 keeps written bit 0 and drives `resp_cfg_o`.
- R12: A write whose byte strobes are not all four set, or whose address has bits 1:0 nonzero, changes nothing. Unmapped offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes; only 4'hF is accepted |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ctrl_src_i | input | 10 | Protection-controller violation levels |
| ctrl_clr_o | output | 10 | Per-controller clear pulse |
| ctrl_en_o | output | 10 | Per-controller interrupt enable |
| mchk_int_i | input | 4 | Internal memory-checker violation levels |
| mchk_exp_i | input | 4 | Expansion memory-checker violation levels |
| wrap_src_i | input | 4 | Master-wrapper violation levels |
| wrap_clr_o | output | 4 | Per-wrapper clear pulse |
| wrap_ns_o | output | 4 | Per-wrapper non-secure control |
| wrap_irq_o | output | 1 | Combined wrapper interrupt |
| resp_cfg_o | output | 1 | Response-mode flag |
| gate_cfg_o | output | 2 | Gating configuration field |

## Verification
The bench drives a source change into a controller in the same cycle as a clear that targets it. A design that lets the clear win would lose a fresh violation and read the bit as zero. The clear pulse is checked against the post-clear status rather than the written mask: a design that echoes the written bits would pulse the sources that were just cleared. Sparse-position tests light the sources at group edges (indices 1, 2, 5, 6, 9). A mapping that is off by one would land a bit in the unimplemented gaps at 2..3, 8..19 or 24..31, or would drive the wrong enable wire. Sub-word and misaligned writes are aimed at live registers, so a design that ignores the strobes would visibly change the configuration pins.

// File: rtl/secviol_pkg.sv
package secviol_pkg;

    localparam int DW          = 32;
    localparam int GRP_A_BASE  = 4;
    localparam int GRP_B_BASE  = 20;
    localparam int EXP_BASE    = 16;

    // word index = byte offset >> 2
    typedef enum logic [5:0] {
        RA_RESP  = 6'h00,
        RA_GATE  = 6'h01,
        RA_MCHK  = 6'h02,
        RA_CSTAT = 6'h04,
        RA_CCLR  = 6'h05,
        RA_CEN   = 6'h06,
        RA_WSTAT = 6'h08,
        RA_WCLR  = 6'h09,
        RA_WEN   = 6'h0A,
        RA_WNS   = 6'h0B,
        RA_BSTAT = 6'h0C,
        RA_BCLR  = 6'h0D,
        RA_BEN   = 6'h0E
    } reg_idx_e;

    // bit position of controller source i inside the status word
    function automatic int ctrl_pos(input int i, input int n_int, input int n_a);
        if (i < n_int)
            return i;
        else if (i < n_int + n_a)
            return GRP_A_BASE + i - n_int;
        else
            return GRP_B_BASE + i - n_int - n_a;
    endfunction

endpackage

// File: rtl/svi_ctrl_bank.sv
module svi_ctrl_bank
    import secviol_pkg::*;
#(
    parameter int N_INT = 2,
    parameter int N_A   = 4,
    parameter int N_B   = 4,
    localparam int N    = N_INT + N_A + N_B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_i,
    input  logic          clr_we,
    input  logic          en_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stat_word,
    output logic [DW-1:0] en_word,
    output logic [N-1:0]  clr_o,
    output logic [N-1:0]  en_o
);

    logic [N-1:0] prev_q, stat_q, stat_nx, en_q, sel_mask;

    // written bit seen by each source at its own position
    always_comb begin
        for (int i = 0; i < N; i++)
            sel_mask[i] = wdata[ctrl_pos(i, N_INT, N_A)];
    end

    // a level change outranks a clear in the same cycle
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (src_i[i] != prev_q[i])
                stat_nx[i] = src_i[i];
            else if (clr_we && sel_mask[i])
                stat_nx[i] = 1'b0;
            else
                stat_nx[i] = stat_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
            en_q   <= '0;
            clr_o  <= '0;
        end else begin
            prev_q <= src_i;
            stat_q <= stat_nx;
            if (en_we)
                en_q <= sel_mask;
            clr_o <= clr_we ? stat_nx : '0;
        end
    end

    always_comb begin
        stat_word = '0;
        en_word   = '0;
        for (int i = 0; i < N; i++) begin
            stat_word[ctrl_pos(i, N_INT, N_A)] = stat_q[i];
            en_word[ctrl_pos(i, N_INT, N_A)]   = en_q[i];
        end
    end

    assign en_o = en_q;

    AST_CAPTURE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != prev_q) |=> (((stat_q ^ $past(src_i)) & $past(src_i ^ prev_q)) == '0)); // R2
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (src_i == prev_q)) |=> ((stat_q & $past(sel_mask)) == '0)); // R3
    AST_CLR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> $past(clr_we)); // R4
    AST_EN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> (en_o == $past(sel_mask))); // R5

endmodule

// File: rtl/svi_wrap_bank.sv
module svi_wrap_bank
    import secviol_pkg::*;
#(
    parameter int N_WRAP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_WRAP-1:0] src_i,
    input  logic              clr_we,
    input  logic              en_we,
    input  logic              ns_we,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     stat_word,
    output logic [DW-1:0]     en_word,
    output logic [DW-1:0]     ns_word,
    output logic [N_WRAP-1:0] clr_o,
    output logic [N_WRAP-1:0] ns_o,
    output logic              irq_o
);

    logic [N_WRAP-1:0] stat_q;
    logic [DW-1:0]     en_q, ns_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
            ns_q   <= '0;
            clr_o  <= '0;
        end else begin
            stat_q <= src_i;
            if (en_we) en_q <= wdata;
            if (ns_we) ns_q <= wdata;
            clr_o <= clr_we ? wdata[EXP_BASE +: N_WRAP] : '0;
        end
    end

    always_comb begin
        stat_word = '0;
        stat_word[EXP_BASE +: N_WRAP] = stat_q;
    end

    assign en_word = en_q;
    assign ns_word = ns_q;
    assign ns_o    = ns_q[EXP_BASE +: N_WRAP];
    assign irq_o   = |(stat_word & en_q);

    AST_WCLR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> $past(clr_we)); // R8
    AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|stat_q)); // R7
    AST_NS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ns_we |=> (ns_o == $past(wdata[EXP_BASE +: N_WRAP]))); // R9

endmodule

// File: rtl/svi_misc_regs.sv
module svi_misc_regs
    import secviol_pkg::*;
#(
    parameter int N_MCHK     = 4,
    parameter int N_MCHK_EXP = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_MCHK-1:0]     mchk_int_i,
    input  logic [N_MCHK_EXP-1:0] mchk_exp_i,
    input  logic                  resp_we,
    input  logic                  gate_we,
    input  logic                  ben_we,
    input  logic [1:0]            wdata_lo,
    input  logic [15:0]           wdata_hi,
    output logic [DW-1:0]         mchk_word,
    output logic [DW-1:0]         ben_word,
    output logic                  resp_o,
    output logic [1:0]            gate_o
);

    logic [N_MCHK-1:0]     int_q;
    logic [N_MCHK_EXP-1:0] exp_q;
    logic [15:0]           ben_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= '0;
            exp_q  <= '0;
            ben_q  <= '0;
            resp_o <= 1'b0;
            gate_o <= 2'b00;
        end else begin
            int_q <= mchk_int_i;
            exp_q <= mchk_exp_i;
            if (ben_we)  ben_q  <= wdata_hi;
            if (resp_we) resp_o <= wdata_lo[0];
            if (gate_we) gate_o <= wdata_lo;
        end
    end

    always_comb begin
        mchk_word = '0;
        mchk_word[N_MCHK-1:0]               = int_q;
        mchk_word[EXP_BASE +: N_MCHK_EXP]   = exp_q;
    end

    assign ben_word = {ben_q, 16'h0000};

    AST_GATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        gate_we |=> (gate_o == $past(wdata_lo))); // R11
    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_we |=> $stable(resp_o)); // R11

endmodule

// File: rtl/secviol_agg.sv
module secviol_agg
    import secviol_pkg::*;
#(
    parameter int N_INT      = 2,
    parameter int N_A        = 4,
    parameter int N_B        = 4,
    parameter int N_MCHK     = 4,
    parameter int N_MCHK_EXP = 4,
    parameter int N_WRAP     = 4,
    parameter int AW         = 8,
    localparam int N_CTRL    = N_INT + N_A + N_B
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    input  logic [3:0]            bus_wstrb,
    output logic [DW-1:0]         bus_rdata,
    input  logic [N_CTRL-1:0]     ctrl_src_i,
    output logic [N_CTRL-1:0]     ctrl_clr_o,
    output logic [N_CTRL-1:0]     ctrl_en_o,
    input  logic [N_MCHK-1:0]     mchk_int_i,
    input  logic [N_MCHK_EXP-1:0] mchk_exp_i,
    input  logic [N_WRAP-1:0]     wrap_src_i,
    output logic [N_WRAP-1:0]     wrap_clr_o,
    output logic [N_WRAP-1:0]     wrap_ns_o,
    output logic                  wrap_irq_o,
    output logic                  resp_cfg_o,
    output logic [1:0]            gate_cfg_o
);

    logic [5:0]    widx;
    logic          wr_ok;
    logic          we_resp, we_gate, we_cclr, we_cen, we_wclr, we_wen, we_wns, we_ben;
    logic [DW-1:0] cstat_w, cen_w, wstat_w, wen_w, wns_w, mchk_w, ben_w;

    assign widx  = bus_addr[7:2];
    assign wr_ok = bus_wr && (bus_wstrb == 4'hF) && (bus_addr[1:0] == 2'b00);

    always_comb begin
        we_resp = 1'b0; we_gate = 1'b0; we_cclr = 1'b0; we_cen = 1'b0;
        we_wclr = 1'b0; we_wen  = 1'b0; we_wns  = 1'b0; we_ben = 1'b0;
        if (wr_ok) begin
            case (widx)
                RA_RESP: we_resp = 1'b1;
                RA_GATE: we_gate = 1'b1;
                RA_CCLR: we_cclr = 1'b1;
                RA_CEN:  we_cen  = 1'b1;
                RA_WCLR: we_wclr = 1'b1;
                RA_WEN:  we_wen  = 1'b1;
                RA_WNS:  we_wns  = 1'b1;
                RA_BEN:  we_ben  = 1'b1;
                default: ;
            endcase
        end
    end

    svi_ctrl_bank #(.N_INT(N_INT), .N_A(N_A), .N_B(N_B)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(ctrl_src_i),
        .clr_we(we_cclr), .en_we(we_cen), .wdata(bus_wdata),
        .stat_word(cstat_w), .en_word(cen_w),
        .clr_o(ctrl_clr_o), .en_o(ctrl_en_o)
    );

    svi_wrap_bank #(.N_WRAP(N_WRAP)) u_wrap (
        .clk(clk), .rst_n(rst_n), .src_i(wrap_src_i),
        .clr_we(we_wclr), .en_we(we_wen), .ns_we(we_wns), .wdata(bus_wdata),
        .stat_word(wstat_w), .en_word(wen_w), .ns_word(wns_w),
        .clr_o(wrap_clr_o), .ns_o(wrap_ns_o), .irq_o(wrap_irq_o)
    );

    svi_misc_regs #(.N_MCHK(N_MCHK), .N_MCHK_EXP(N_MCHK_EXP)) u_misc (
        .clk(clk), .rst_n(rst_n),
        .mchk_int_i(mchk_int_i), .mchk_exp_i(mchk_exp_i),
        .resp_we(we_resp), .gate_we(we_gate), .ben_we(we_ben),
        .wdata_lo(bus_wdata[1:0]), .wdata_hi(bus_wdata[31:16]),
        .mchk_word(mchk_w), .ben_word(ben_w),
        .resp_o(resp_cfg_o), .gate_o(gate_cfg_o)
    );

    always_comb begin
        case (widx)
            RA_RESP:  bus_rdata = {{(DW-1){1'b0}}, resp_cfg_o};
            RA_GATE:  bus_rdata = {{(DW-2){1'b0}}, gate_cfg_o};
            RA_MCHK:  bus_rdata = mchk_w;
            RA_CSTAT: bus_rdata = cstat_w;
            RA_CEN:   bus_rdata = cen_w;
            RA_WSTAT: bus_rdata = wstat_w;
            RA_WEN:   bus_rdata = wen_w;
            RA_WNS:   bus_rdata = wns_w;
            RA_BEN:   bus_rdata = ben_w;
            default:  bus_rdata = '0;
        endcase
    end

    AST_PARTIAL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_wstrb != 4'hF)) |=>
            ($stable(resp_cfg_o) && $stable(gate_cfg_o) && $stable(ctrl_en_o) && $stable(wrap_ns_o))); // R12
    AST_CLEAR_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !((|ctrl_clr_o) && (|wrap_clr_o))); // R4

endmodule

// File: tb/secviol_agg_test.sv
`timescale 1ns/1ps
module secviol_agg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = 4'hF;
    logic [31:0] bus_rdata;
    logic [9:0]  ctrl_src_i = '0;
    logic [9:0]  ctrl_clr_o, ctrl_en_o;
    logic [3:0]  mchk_int_i = '0, mchk_exp_i = '0, wrap_src_i = '0;
    logic [3:0]  wrap_clr_o, wrap_ns_o;
    logic        wrap_irq_o, resp_cfg_o;
    logic [1:0]  gate_cfg_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    secviol_agg uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
        .ctrl_src_i(ctrl_src_i), .ctrl_clr_o(ctrl_clr_o), .ctrl_en_o(ctrl_en_o),
        .mchk_int_i(mchk_int_i), .mchk_exp_i(mchk_exp_i),
        .wrap_src_i(wrap_src_i), .wrap_clr_o(wrap_clr_o), .wrap_ns_o(wrap_ns_o),
        .wrap_irq_o(wrap_irq_o), .resp_cfg_o(resp_cfg_o), .gate_cfg_o(gate_cfg_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // returns at the falling edge right after the capturing edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = 4'hF;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 ctrl_clr_o", {22'd0, ctrl_clr_o}, 0);
        chk("R1 ctrl_en_o",  {22'd0, ctrl_en_o}, 0);
        chk("R1 wrap outs",  {24'd0, wrap_clr_o, wrap_ns_o}, 0);
        chk("R1 irq/cfg",    {29'd0, wrap_irq_o, resp_cfg_o, gate_cfg_o[0] | gate_cfg_o[1]}, 0);
        foreach (d[k]) ; // no-op keeps d declared before reads
        rd(8'h00, d); chk("R1 resp reg", d, 0);
        rd(8'h04, d); chk("R1 gate reg", d, 0);
        rd(8'h10, d); chk("R1 cstat", d, 0);
        rd(8'h18, d); chk("R1 cen", d, 0);
        rd(8'h28, d); chk("R1 wen", d, 0);
        rd(8'h2C, d); chk("R1 wns", d, 0);
        rd(8'h38, d); chk("R1 ben", d, 0);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        @(negedge clk); ctrl_src_i = 10'b10_0000_0101;   // idx 0,2,9
        @(negedge clk); rd(8'h10, d); chk("R2 sparse map 0/2/9", d, 32'h0080_0011);
        @(negedge clk); ctrl_src_i = 10'b10_0000_0001;   // drop idx 2
        @(negedge clk); rd(8'h10, d); chk("R2 level fall", d, 32'h0080_0001);
        @(negedge clk); ctrl_src_i = 10'b11_1111_1111;
        @(negedge clk); rd(8'h10, d); chk("R2 all sources", d, 32'h00F0_00F3);
        @(negedge clk); ctrl_src_i = 10'b00_0110_0010;   // idx 1,5,6 at group edges
        @(negedge clk); rd(8'h10, d); chk("R2 group edges", d, 32'h0010_0082);
        @(negedge clk); ctrl_src_i = 10'b11_1111_1111;
        @(negedge clk);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(8'h14, 32'h0000_0001);
        chk("R4 pulse post-clear", {22'd0, ctrl_clr_o}, 32'h3FE);
        rd(8'h10, d); chk("R3 w1c bit0", d, 32'h00F0_00F2);
        @(negedge clk);
        chk("R4 pulse one cycle", {22'd0, ctrl_clr_o}, 0);
        rd(8'h14, d); chk("R3 clear reads zero", d, 0);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R3 clear all", d, 0);
        chk("R4 pulse empty status", {22'd0, ctrl_clr_o}, 0);
        @(negedge clk); ctrl_src_i = '0;
        @(negedge clk); @(negedge clk);
        // rise on idx1 in the same cycle as a clear of bit 1
        bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h0000_0002; ctrl_src_i = 10'b00_0000_0010;
        @(negedge clk); bus_wr = 1'b0;
        rd(8'h10, d); chk("R3 change beats clear", d, 32'h0000_0002);
        chk("R4 pulse carries kept bit", {22'd0, ctrl_clr_o}, 32'h002);
        @(negedge clk); ctrl_src_i = '0;
        @(negedge clk);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); chk("R5 enable masked", d, 32'h00F0_00F3);
        chk("R5 all enables", {22'd0, ctrl_en_o}, 32'h3FF);
        wr(8'h18, 32'h0010_0010);
        chk("R5 enable pos4/pos20", {22'd0, ctrl_en_o}, 32'h044);
        rd(8'h18, d); chk("R5 enable readback", d, 32'h0010_0010);
    endtask

    task automatic t_mchk();
        logic [31:0] d;
        @(negedge clk); mchk_int_i = 4'b0101; mchk_exp_i = 4'b1001;
        @(negedge clk); rd(8'h08, d); chk("R6 mchk map", d, 32'h0009_0005);
        wr(8'h08, 32'h0000_0000);
        rd(8'h08, d); chk("R6 mchk read-only", d, 32'h0009_0005);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        @(negedge clk); wrap_src_i = 4'b0010;
        @(negedge clk); rd(8'h20, d); chk("R7 wrap status", d, 32'h0002_0000);
        chk("R7 irq off no enable", {31'd0, wrap_irq_o}, 0);
        wr(8'h28, 32'h0002_0000);
        chk("R7 irq on", {31'd0, wrap_irq_o}, 1);
        wr(8'h28, 32'h0004_0000);
        chk("R7 irq other bit", {31'd0, wrap_irq_o}, 0);
        wr(8'h28, 32'hFFFF_0001);
        rd(8'h28, d); chk("R7 enable full word", d, 32'hFFFF_0001);
        @(negedge clk); wrap_src_i = 4'b0000;
        @(negedge clk); chk("R7 irq drops with status", {31'd0, wrap_irq_o}, 0);
        wr(8'h24, 32'h000A_0005);
        chk("R8 wrap clear pulse", {28'd0, wrap_clr_o}, 32'hA);
        @(negedge clk);
        chk("R8 wrap pulse one cycle", {28'd0, wrap_clr_o}, 0);
        rd(8'h24, d); chk("R8 clear reads zero", d, 0);
        wr(8'h2C, 32'h0005_0003);
        chk("R9 ns outputs", {28'd0, wrap_ns_o}, 32'h5);
        rd(8'h2C, d); chk("R9 ns readback", d, 32'h0005_0003);
    endtask

    task automatic t_bridge();
        logic [31:0] d;
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, d); chk("R10 bridge status zero", d, 0);
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h38, d); chk("R10 bridge enable upper", d, 32'hFFFF_0000);
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h38, d); chk("R10 bridge clear no effect", d, 32'hFFFF_0000);
        rd(8'h34, d); chk("R10 bridge clear reads zero", d, 0);
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        wr(8'h04, 32'hFFFF_FFFF);
        chk("R11 gate pin", {30'd0, gate_cfg_o}, 3);
        rd(8'h04, d); chk("R11 gate readback", d, 3);
        wr(8'h00, 32'hFFFF_FFFE);
        chk("R11 resp bit0 only", {31'd0, resp_cfg_o}, 0);
        wr(8'h00, 32'h0000_0001);
        chk("R11 resp pin", {31'd0, resp_cfg_o}, 1);
    endtask

    task automatic t_partial();
        logic [31:0] d;
        wr(8'h04, 32'h0000_0000, 4'h1);
        chk("R12 byte write ignored", {30'd0, gate_cfg_o}, 3);
        wr(8'h01, 32'h0000_0000);
        chk("R12 misaligned write ignored", {31'd0, resp_cfg_o}, 1);
        wr(8'h2C, 32'h0000_0000, 4'h7);
        chk("R12 partial ns ignored", {28'd0, wrap_ns_o}, 32'h5);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, d); chk("R12 unmapped reads zero", d, 0);
        rd(8'hFC, d); chk("R12 top offset zero", d, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture();
        t_clear();
        t_enable();
        t_mchk();
        t_wrap();
        t_bridge();
        t_cfg();
        t_partial();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule